// File: doc/BRIEF.md
# Snoop Responder with Coherence Invalidation

This block sits beside one private cache in a shared-bus multiprocessor and answers the bus snoops raised by the other caches. It holds a small direct-mapped store of line tags, line states and line data. Each snooped line address is compared against that store. A remote write removes a matching local copy. A remote read leaves a clean copy alone. When the local copy is dirty, the block sends the whole line straight to the requester, so the line does not come from memory. A memory-side observer on the bus may also capture those beats to bring memory up to date. After such a transfer the local copy becomes clean (remote read) or invalid (remote write), so at most one cache ever owns the line dirty.

The local core reaches the same store through a one-beat access port. That port can fill a beat, write a beat, or just look up the state and data of a line. A snoop lookup wins over a local access. The core is told to retry in the cycle where the lookup takes place. Each snoop gets a response exactly two cycles after it is accepted, and the data beats follow in consecutive cycles when the line is supplied.

Top module: `snoop_inval_unit`

## Requirements
- R1: After reset every line reads as invalid on `lclState` (state codes: 0 invalid, 1 clean, 2 dirty).
- R2: A local access with `lclOp` 1 (fill) or 2 (write) stores `lclData` into beat `lclBeat` of the addressed line. The low `SET_BITS` of a line address select the set and the remaining upper bits form the tag. If the tag does not match a valid line, the line is replaced: its tag is set and all other beats are cleared. A write leaves the line dirty. A fill leaves a new line clean and keeps the state of a matching line.
- R3: A remote read that hits a clean line reports a hit without supply, and the line stays clean with its data intact.
- R4: A remote write that hits a clean line reports a hit without supply, and the line becomes invalid.
- R5: A remote read that hits a dirty line reports a hit with supply, sends all beats, and leaves the line clean.
- R6: A remote write that hits a dirty line reports a hit with supply, sends all beats, and leaves the line invalid.
- R7: A snoop whose tag does not match a valid line reports neither hit nor supply and changes no line.
- R8: `rspValid` is high for one cycle exactly two cycles after the cycle in which a snoop is accepted. When supplying, `rspDataValid` is high for the next `BEATS` cycles, with beats 0 up to `BEATS-1` in order, and then falls.
- R9: In the cycle after a snoop is accepted, `lclReady` is low, and a local access driven in that cycle has no effect.
- R10: `snpReady` is low from acceptance until the last data beat has been sent, and a snoop driven while it is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| snpValid | input | 1 | Snoop request present |
| snpWrite | input | 1 | Snoop is a remote write (0 = remote read) |
| snpAddr | input | LINE_ADDR_W | Snooped line address |
| snpReady | output | 1 | Responder can accept a snoop this cycle |
| rspValid | output | 1 | Snoop response valid |
| rspHit | output | 1 | Snooped line is held locally |
| rspSupply | output | 1 | Line was dirty and its data will follow |
| rspDataValid | output | 1 | Data beat valid on rspData |
| rspData | output | DATA_W | Supplied line beat |
| lclOp | input | 2 | Local access: 0 none, 1 fill, 2 write |
| lclAddr | input | LINE_ADDR_W | Local line address |
| lclBeat | input | $clog2(BEATS) | Local beat index |
| lclData | input | DATA_W | Local write data |
| lclReady | output | 1 | Local access accepted this cycle (low means retry) |
| lclState | output | 2 | State of the addressed line (invalid on tag mismatch) |
| lclRdData | output | DATA_W | Addressed beat of a matching line, else zero |

## Verification
The snoop path is tried with remote reads and remote writes against lines that are invalid, clean with a matching tag, clean or dirty with a different tag in the same set, and dirty with a matching tag. These cases separate hit from miss and supply from no supply. They also separate the two follow-on states, clean after a read and invalid after a write. A seeded random mix of fills, writes and snoops over a few tags per set checks that state and data stay consistent over long runs. Directed sequences place a local write and a second snoop inside the busy window to show that both are dropped.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    LN_INV   = 2'd0,
    LN_CLEAN = 2'd1,
    LN_DIRTY = 2'd2
  } lineState_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_FILL  = 2'd1,
    OP_WRITE = 2'd2
  } lclOp_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic capture;  // latch an accepted snoop
    logic apply;    // look up the latched snoop and update the line
    logic shift;    // advance the supply buffer by one beat
  } snpStrobe_t;
endpackage

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int BEATS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       snpValid,
  input  logic       lkDirty,
  output snpStrobe_t stb,
  output logic       snpReady,
  output logic       lclReady,
  output logic       rspValid,
  output logic       rspDataValid
);
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic              lookupQ;
  logic              pendSupply;
  logic              dataActive;
  logic [BEAT_W-1:0] beatCnt;

  assign snpReady     = !(lookupQ || pendSupply || dataActive);
  assign lclReady     = !lookupQ;
  assign rspDataValid = dataActive;

  always_comb begin
    stb.capture = snpValid && snpReady;
    stb.apply   = lookupQ;
    stb.shift   = dataActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lookupQ    <= 1'b0;
      rspValid   <= 1'b0;
      pendSupply <= 1'b0;
      dataActive <= 1'b0;
      beatCnt    <= '0;
    end else begin
      lookupQ    <= snpValid && snpReady;
      rspValid   <= lookupQ;
      pendSupply <= lookupQ && lkDirty;
      if (pendSupply) begin
        dataActive <= 1'b1;
        beatCnt    <= '0;
      end else if (dataActive) begin
        if (beatCnt == LAST_BEAT) dataActive <= 1'b0;
        else                      beatCnt    <= beatCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/snoop_datapath.sv
module snoop_datapath
  import snoop_pkg::*;
#(
  parameter int LINE_ADDR_W = 10,
  parameter int SET_BITS    = 2,
  parameter int DATA_W      = 32,
  parameter int BEATS       = 8
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  snpStrobe_t                                  stb,
  input  logic                                        snpWrite,
  input  logic [LINE_ADDR_W-1:0]                      snpAddr,
  input  lclOp_e                                      lclOp,
  input  logic                                        lclEn,
  input  logic [LINE_ADDR_W-1:0]                      lclAddr,
  input  logic [((BEATS > 1) ? $clog2(BEATS) : 1)-1:0] lclBeat,
  input  logic [DATA_W-1:0]                           lclData,
  output logic                                        lkDirty,
  output logic                                        rspHitQ,
  output logic                                        rspDirtyQ,
  output logic [DATA_W-1:0]                           rspData,
  output logic [1:0]                                  lclState,
  output logic [DATA_W-1:0]                           lclRdData
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = LINE_ADDR_W - SET_BITS;

  lineState_e        stateArr [SETS];
  logic [TAG_W-1:0]  tagArr   [SETS];
  logic [DATA_W-1:0] dataArr  [SETS][BEATS];
  logic [DATA_W-1:0] bufQ     [BEATS];

  logic [LINE_ADDR_W-1:0] s1Addr;
  logic                   s1Write;

  logic [SET_BITS-1:0] s1Set, lSet;
  logic [TAG_W-1:0]    s1Tag, lTag;
  logic                lkHit, lMatch;

  assign s1Set   = s1Addr[SET_BITS-1:0];
  assign s1Tag   = s1Addr[LINE_ADDR_W-1:SET_BITS];
  assign lSet    = lclAddr[SET_BITS-1:0];
  assign lTag    = lclAddr[LINE_ADDR_W-1:SET_BITS];
  assign lkHit   = (stateArr[s1Set] != LN_INV) && (tagArr[s1Set] == s1Tag);
  assign lkDirty = lkHit && (stateArr[s1Set] == LN_DIRTY);
  assign lMatch  = (stateArr[lSet] != LN_INV) && (tagArr[lSet] == lTag);

  assign lclState  = lMatch ? stateArr[lSet] : LN_INV;
  assign lclRdData = lMatch ? dataArr[lSet][lclBeat] : '0;
  assign rspData   = bufQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Addr  <= '0;
      s1Write <= 1'b0;
    end else if (stb.capture) begin
      s1Addr  <= snpAddr;
      s1Write <= snpWrite;
    end
  end

  // line store: snoop update has priority over the local port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        stateArr[s] <= LN_INV;
        tagArr[s]   <= '0;
        for (int b = 0; b < BEATS; b++) dataArr[s][b] <= '0;
      end
    end else if (stb.apply) begin
      if (lkHit) begin
        if (s1Write)      stateArr[s1Set] <= LN_INV;
        else if (lkDirty) stateArr[s1Set] <= LN_CLEAN;
      end
    end else if (lclEn) begin
      if (!lMatch) begin
        tagArr[lSet] <= lTag;
        for (int b = 0; b < BEATS; b++) dataArr[lSet][b] <= '0;
      end
      dataArr[lSet][lclBeat] <= lclData;
      if (lclOp == OP_WRITE) stateArr[lSet] <= LN_DIRTY;
      else if (!lMatch)      stateArr[lSet] <= LN_CLEAN;
    end
  end

  // response flags and supply buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspHitQ   <= 1'b0;
      rspDirtyQ <= 1'b0;
      for (int b = 0; b < BEATS; b++) bufQ[b] <= '0;
    end else if (stb.apply) begin
      rspHitQ   <= lkHit;
      rspDirtyQ <= lkDirty;
      for (int b = 0; b < BEATS; b++) bufQ[b] <= dataArr[s1Set][b];
    end else if (stb.shift) begin
      for (int b = 0; b < BEATS - 1; b++) bufQ[b] <= bufQ[b+1];
      bufQ[BEATS-1] <= '0;
    end
  end
endmodule

// File: rtl/snoop_inval_unit.sv
module snoop_inval_unit
  import snoop_pkg::*;
#(
  parameter int LINE_ADDR_W = 10,
  parameter int SET_BITS    = 2,
  parameter int DATA_W      = 32,
  parameter int BEATS       = 8
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        snpValid,
  input  logic                                        snpWrite,
  input  logic [LINE_ADDR_W-1:0]                      snpAddr,
  output logic                                        snpReady,
  output logic                                        rspValid,
  output logic                                        rspHit,
  output logic                                        rspSupply,
  output logic                                        rspDataValid,
  output logic [DATA_W-1:0]                           rspData,
  input  logic [1:0]                                  lclOp,
  input  logic [LINE_ADDR_W-1:0]                      lclAddr,
  input  logic [((BEATS > 1) ? $clog2(BEATS) : 1)-1:0] lclBeat,
  input  logic [DATA_W-1:0]                           lclData,
  output logic                                        lclReady,
  output logic [1:0]                                  lclState,
  output logic [DATA_W-1:0]                           lclRdData
);
  snpStrobe_t stb;
  logic       lkDirty, rspHitQ, rspDirtyQ, lclEn;
  lclOp_e     lclOpE;

  assign lclOpE    = lclOp_e'(lclOp);
  assign lclEn     = lclReady && (lclOpE == OP_FILL || lclOpE == OP_WRITE);
  assign rspHit    = rspValid && rspHitQ;
  assign rspSupply = rspValid && rspDirtyQ;

  snoop_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .snpValid     (snpValid),
    .lkDirty      (lkDirty),
    .stb          (stb),
    .snpReady     (snpReady),
    .lclReady     (lclReady),
    .rspValid     (rspValid),
    .rspDataValid (rspDataValid)
  );

  snoop_datapath #(
    .LINE_ADDR_W (LINE_ADDR_W),
    .SET_BITS    (SET_BITS),
    .DATA_W      (DATA_W),
    .BEATS       (BEATS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .snpWrite  (snpWrite),
    .snpAddr   (snpAddr),
    .lclOp     (lclOpE),
    .lclEn     (lclEn),
    .lclAddr   (lclAddr),
    .lclBeat   (lclBeat),
    .lclData   (lclData),
    .lkDirty   (lkDirty),
    .rspHitQ   (rspHitQ),
    .rspDirtyQ (rspDirtyQ),
    .rspData   (rspData),
    .lclState  (lclState),
    .lclRdData (lclRdData)
  );
endmodule

// File: rtl/snoop_inval_chk.sv
module snoop_inval_chk #(
  parameter int BEATS = 8
) (
  input logic clk,
  input logic rstN,
  input logic snpValid,
  input logic snpReady,
  input logic rspValid,
  input logic rspHit,
  input logic rspSupply,
  input logic rspDataValid,
  input logic lclReady
);
  localparam int CNT_W = $clog2(BEATS + 1) + 1;
  logic [CNT_W-1:0] beatSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             beatSeen <= '0;
    else if (rspDataValid) beatSeen <= beatSeen + 1'b1;
    else                   beatSeen <= '0;
  end

  // R8
  rsp_two_cycles_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpReady) |-> ##2 rspValid);

  // R9
  lcl_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpReady) |=> !lclReady);

  // R5
  supply_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspSupply |-> rspHit);

  // R8
  supply_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspSupply) |=> rspDataValid);

  // R8
  beat_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rspDataValid) |-> (beatSeen == CNT_W'(BEATS)));

  // R10
  busy_while_beats_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDataValid |-> !snpReady);
endmodule

bind snoop_inval_unit snoop_inval_chk #(.BEATS(BEATS)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .snpValid     (snpValid),
  .snpReady     (snpReady),
  .rspValid     (rspValid),
  .rspHit       (rspHit),
  .rspSupply    (rspSupply),
  .rspDataValid (rspDataValid),
  .lclReady     (lclReady)
);

// File: tb/snoop_inval_unit_tb.sv
module snoop_inval_unit_tb;
  localparam int LINE_ADDR_W = 10;
  localparam int SET_BITS    = 2;
  localparam int DATA_W      = 32;
  localparam int BEATS       = 8;
  localparam int SETS        = 1 << SET_BITS;
  localparam int TAG_W       = LINE_ADDR_W - SET_BITS;
  localparam int BEAT_W      = $clog2(BEATS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic snpValid = 1'b0, snpWrite = 1'b0;
  logic [LINE_ADDR_W-1:0] snpAddr = '0;
  logic snpReady, rspValid, rspHit, rspSupply, rspDataValid;
  logic [DATA_W-1:0] rspData;
  logic [1:0] lclOp = 2'd0;
  logic [LINE_ADDR_W-1:0] lclAddr = '0;
  logic [BEAT_W-1:0] lclBeat = '0;
  logic [DATA_W-1:0] lclData = '0;
  logic lclReady;
  logic [1:0] lclState;
  logic [DATA_W-1:0] lclRdData;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [1:0]        mState [SETS];
  logic [TAG_W-1:0]  mTag   [SETS];
  logic [DATA_W-1:0] mData  [SETS][BEATS];

  always #10 clk = ~clk;

  snoop_inval_unit #(
    .LINE_ADDR_W(LINE_ADDR_W), .SET_BITS(SET_BITS), .DATA_W(DATA_W), .BEATS(BEATS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .snpValid(snpValid), .snpWrite(snpWrite), .snpAddr(snpAddr),
    .snpReady(snpReady), .rspValid(rspValid), .rspHit(rspHit), .rspSupply(rspSupply),
    .rspDataValid(rspDataValid), .rspData(rspData), .lclOp(lclOp), .lclAddr(lclAddr),
    .lclBeat(lclBeat), .lclData(lclData), .lclReady(lclReady), .lclState(lclState),
    .lclRdData(lclRdData)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LINE_ADDR_W-1:0] mkAddr(input int tag, input int set);
    return {TAG_W'(tag), SET_BITS'(set)};
  endfunction

  function automatic bit modelHit(input logic [LINE_ADDR_W-1:0] a);
    return mState[a[SET_BITS-1:0]] != 2'd0 && mTag[a[SET_BITS-1:0]] == a[LINE_ADDR_W-1:SET_BITS];
  endfunction

  function automatic logic [1:0] modelState(input logic [LINE_ADDR_W-1:0] a);
    return modelHit(a) ? mState[a[SET_BITS-1:0]] : 2'd0;
  endfunction

  // read state and one beat through the local port, compare with the model
  task automatic probe(input logic [LINE_ADDR_W-1:0] a, input int beat, input string req);
    logic [1:0] es;
    logic [DATA_W-1:0] ed;
    lclOp = 2'd0; lclAddr = a; lclBeat = BEAT_W'(beat);
    #1;
    es = modelState(a);
    ed = (es != 2'd0) ? mData[a[SET_BITS-1:0]][beat] : '0;
    chk(lclState == es, {req, " state"}, 64'(lclState), 64'(es));
    chk(lclRdData == ed, {req, " data"}, 64'(lclRdData), 64'(ed));
  endtask

  task automatic doLocal(input logic [1:0] op, input logic [LINE_ADDR_W-1:0] a,
                         input int beat, input logic [DATA_W-1:0] d);
    int s;
    bit hit;
    @(negedge clk);
    while (!lclReady) @(negedge clk);
    hit = modelHit(a);
    lclOp = op; lclAddr = a; lclBeat = BEAT_W'(beat); lclData = d;
    @(negedge clk);
    lclOp = 2'd0;
    s = int'(a[SET_BITS-1:0]);
    if (!hit) begin
      mTag[s] = a[LINE_ADDR_W-1:SET_BITS];
      for (int b = 0; b < BEATS; b++) mData[s][b] = '0;
    end
    mData[s][beat] = d;
    if (op == 2'd2) mState[s] = 2'd2;
    else if (!hit) mState[s] = 2'd1;
  endtask

  // one snoop with full response checking; optional injected local write in
  // the lookup cycle and injected snoop during the supply beats
  task automatic doSnoop(input bit wr, input logic [LINE_ADDR_W-1:0] a,
                         input bit injLcl, input logic [LINE_ADDR_W-1:0] lclA,
                         input bit injSnp, input logic [LINE_ADDR_W-1:0] snpA);
    int s;
    bit eHit, eSup;
    logic [DATA_W-1:0] line [BEATS];
    string req;
    @(negedge clk);
    while (!snpReady) @(negedge clk);
    s = int'(a[SET_BITS-1:0]);
    eHit = modelHit(a);
    eSup = eHit && mState[s] == 2'd2;
    for (int b = 0; b < BEATS; b++) line[b] = mData[s][b];
    if (!eHit) req = "R7";
    else if (!eSup) req = wr ? "R4" : "R3";
    else req = wr ? "R6" : "R5";
    snpValid = 1'b1; snpWrite = wr; snpAddr = a;
    @(negedge clk);  // lookup cycle
    snpValid = 1'b0;
    chk(lclReady == 1'b0, "R9 lclReady low in lookup cycle", 64'(lclReady), 64'd0);
    chk(rspValid == 1'b0, "R8 no response one cycle after", 64'(rspValid), 64'd0);
    if (injLcl) begin
      lclOp = 2'd2; lclAddr = lclA; lclBeat = '0; lclData = 32'hBAD0_0BAD;
    end
    @(negedge clk);  // response cycle
    lclOp = 2'd0;
    chk(rspValid == 1'b1, "R8 response two cycles after", 64'(rspValid), 64'd1);
    chk(rspHit == eHit, {req, " hit flag"}, 64'(rspHit), 64'(eHit));
    chk(rspSupply == eSup, {req, " supply flag"}, 64'(rspSupply), 64'(eSup));
    if (eHit) begin
      if (wr) mState[s] = 2'd0;
      else if (eSup) mState[s] = 2'd1;
    end
    if (eSup) begin
      for (int k = 0; k < BEATS; k++) begin
        @(negedge clk);
        snpValid = 1'b0;
        chk(rspDataValid == 1'b1, "R8 beat valid", 64'(rspDataValid), 64'd1);
        chk(rspData == line[k], {req, " beat data"}, 64'(rspData), 64'(line[k]));
        if (injSnp && k == 2) begin
          chk(snpReady == 1'b0, "R10 not ready while supplying", 64'(snpReady), 64'd0);
          snpValid = 1'b1; snpWrite = 1'b1; snpAddr = snpA;
        end
      end
      @(negedge clk);
      chk(rspDataValid == 1'b0, "R8 beats end", 64'(rspDataValid), 64'd0);
    end else begin
      @(negedge clk);
      chk(rspDataValid == 1'b0, "R8 no beats without supply", 64'(rspDataValid), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++) begin
      mState[s] = 2'd0; mTag[s] = '0;
      for (int b = 0; b < BEATS; b++) mData[s][b] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int s = 0; s < SETS; s++) probe(mkAddr(0, s), 0, "R1 reset");
    chk(snpReady == 1'b1, "R1 ready after reset", 64'(snpReady), 64'd1);

    // R2: fill and write, including replacement clearing other beats
    doLocal(2'd1, mkAddr(3, 0), 1, 32'h1111_0001);
    doLocal(2'd1, mkAddr(3, 0), 5, 32'h1111_0005);
    probe(mkAddr(3, 0), 5, "R2 fill");
    doLocal(2'd2, mkAddr(4, 0), 2, 32'h2222_0002);
    probe(mkAddr(4, 0), 2, "R2 write replaces");
    probe(mkAddr(4, 0), 5, "R2 other beats cleared");
    probe(mkAddr(3, 0), 1, "R2 old tag gone");

    // R7: miss on a dirty set with a different tag
    doSnoop(1'b0, mkAddr(3, 0), 1'b0, '0, 1'b0, '0);
    probe(mkAddr(4, 0), 2, "R7 no change");

    // R3 / R4: clean line
    doLocal(2'd1, mkAddr(7, 1), 0, 32'hC1EA_0000);
    doSnoop(1'b0, mkAddr(7, 1), 1'b0, '0, 1'b0, '0);
    probe(mkAddr(7, 1), 0, "R3 stays clean");
    doSnoop(1'b1, mkAddr(7, 1), 1'b0, '0, 1'b0, '0);
    probe(mkAddr(7, 1), 0, "R4 invalid");

    // R5: dirty line, remote read, with a local write injected in the lookup cycle (R9)
    doLocal(2'd1, mkAddr(9, 3), 0, 32'h0000_3333);
    for (int b = 0; b < BEATS; b++) doLocal(2'd2, mkAddr(5, 2), b, 32'hD000_0000 + b);
    doSnoop(1'b0, mkAddr(5, 2), 1'b1, mkAddr(9, 3), 1'b1, mkAddr(9, 3));
    probe(mkAddr(5, 2), 3, "R5 clean after read supply");
    probe(mkAddr(9, 3), 0, "R9 local write ignored and R10 snoop ignored");

    // R6: dirty line, remote write
    doLocal(2'd2, mkAddr(5, 2), 7, 32'hEEEE_0007);
    doSnoop(1'b1, mkAddr(5, 2), 1'b0, '0, 1'b0, '0);
    probe(mkAddr(5, 2), 7, "R6 invalid after write supply");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int op, tg, st, bt;
      logic [LINE_ADDR_W-1:0] a;
      op = int'($urandom_range(0, 4));
      tg = int'($urandom_range(0, 3));
      st = int'($urandom_range(0, SETS - 1));
      bt = int'($urandom_range(0, BEATS - 1));
      a = mkAddr(tg, st);
      case (op)
        0: doLocal(2'd1, a, bt, $urandom);
        1: doLocal(2'd2, a, bt, $urandom);
        2: doSnoop(1'b0, a, 1'b0, '0, 1'b0, '0);
        3: doSnoop(1'b1, a, 1'b0, '0, 1'b0, '0);
        default: begin
          @(negedge clk);
          probe(a, bt, "R2 random probe");
        end
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule